// File: doc/BRIEF.md
# Doorbell Message Register Interface

This block is the software-visible face of doorbell messaging on a packet interconnect. Incoming doorbells arrive on a simple valid-only message port. Each one carries a 16-bit sender device ID and a 16-bit information payload, and the block places it in a small first-in first-out queue. Software drains the queue through a 32-bit register port. One read of the receive word returns the oldest message and removes it from the queue. Software can also read a count of the messages that are waiting.

For outgoing doorbells, software first sets a request priority. It then writes the destination ID and the information payload in a single word. That write raises a transmit request on a valid/ready port. The request holds steady until the downstream logic accepts it. Three sticky event bits, each with its own enable, drive one interrupt line. A parameter selects 8-bit or 16-bit device IDs. In 8-bit mode the upper ID byte is forced to zero on both the receive side and the transmit side.

Top module: `dbell_regif`

## Requirements
- R1: After reset, reg_rdata is zero, tx_valid is low, irq is low, the queue level reads 0 and the priority reads 0.
- R2: A read at offset 0x00 loads reg_rdata on the same clock edge with the oldest queued message, laid out as {source ID [31:16], information [15:0]}, and removes that message. Messages come out in arrival order.
- R3: The queue holds up to RXQ_DEPTH (default 16) messages. Offset 0x04 bits [7:0] report the level, and the upper bits read zero. A message that arrives while the queue is full, with no pop in the same cycle, is dropped and sets interrupt status bit 1.
- R4: A read at offset 0x00 while the queue is empty returns zero and leaves the level unchanged.
- R5: Offset 0x08 bits [1:0] hold the transmit priority. A written value of 3 is stored as 2, and bits [31:2] read zero.
- R6: A write to offset 0x0C takes the destination ID from wdata[31:16] and the information from wdata[15:0]. From the next cycle it raises tx_valid with the current priority. The request and its fields stay stable until tx_ready is seen. A write to 0x0C while a request is pending is ignored. Offset 0x10 bit 0 reads 1 while a request is pending.
- R7: Interrupt status is at offset 0x24 and the interrupt enable is at offset 0x20 bits [2:0]. Status bit 0 is set when a message is queued, bit 1 on a dropped message, and bit 2 when a transmit request is accepted. A status bit is cleared by writing 1 to it. irq is the OR of the status bits that are enabled.
- R8: With WIDE_ID = 0, bits [31:24] of the receive word read zero and tx_dest_id[15:8] is zero.
- R9: Writes to the read-only offsets 0x00, 0x04 and 0x10 change nothing. Offsets 0x14, 0x18 and 0x1C, and all unmapped offsets, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |
| rx_valid | input | 1 | Incoming doorbell present this cycle |
| rx_src_id | input | 16 | Sender device ID of the incoming doorbell |
| rx_info | input | 16 | Information payload of the incoming doorbell |
| tx_valid | output | 1 | Outgoing doorbell request pending |
| tx_ready | input | 1 | Downstream accepts the request |
| tx_prio | output | 2 | Request priority |
| tx_dest_id | output | 16 | Destination device ID |
| tx_info | output | 16 | Outgoing information payload |
| irq | output | 1 | Interrupt, the OR of the enabled status bits |

## Verification
The properties assume that the register port never asserts reg_rd and reg_wr in the same cycle. The drop and empty-read properties assume that no message arrives in the cycle they examine, unless a pop happens alongside it. The bench drives each register access as a single one-cycle strobe from a task, and it never overlaps a message push with a register access. The hold property for the transmit request needs tx_ready to be a plain acceptance signal, so the bench raises tx_ready for exactly one cycle while a request is pending.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
   // word index = byte address [5:2]
   localparam logic [3:0] W_RX_MSG   = 4'd0;
   localparam logic [3:0] W_RX_LVL   = 4'd1;
   localparam logic [3:0] W_TX_PRIO  = 4'd2;
   localparam logic [3:0] W_TX_MSG   = 4'd3;
   localparam logic [3:0] W_TX_STAT  = 4'd4;
   localparam logic [3:0] W_IRQ_EN   = 4'd8;
   localparam logic [3:0] W_IRQ_STS  = 4'd9;

   localparam int EV_RX_MSG  = 0;
   localparam int EV_RX_DROP = 1;
   localparam int EV_TX_DONE = 2;
   localparam int EV_W       = 3;

   typedef struct packed {
      logic [15:0] src;
      logic [15:0] info;
   } dbell_msg_t;
endpackage

// File: rtl/dbell_rxq.sv
module dbell_rxq
   import dbell_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  dbell_msg_t       push_msg,
   input  logic             pop,
   output dbell_msg_t       head,
   output logic [LVL_W-1:0] level,
   output logic             accepted,
   output logic             dropped
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   dbell_msg_t       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             full, empty, do_pop;

   assign full     = (level == LVL_W'(DEPTH));
   assign empty    = (level == '0);
   assign do_pop   = pop && !empty;
   assign accepted = push && (!full || do_pop);
   assign dropped  = push && full && !do_pop;
   assign head     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accepted) mem[wr_ptr] <= push_msg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (accepted) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({accepted, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/dbell_txreq.sv
module dbell_txreq #(
   parameter bit WIDE_ID = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [15:0] load_dest,
   input  logic [15:0] load_info,
   input  logic [1:0]  load_prio,
   input  logic        tx_ready,
   output logic        tx_valid,
   output logic [15:0] tx_dest_id,
   output logic [15:0] tx_info,
   output logic [1:0]  tx_prio,
   output logic        done
);
   logic [15:0] dest_in;

   generate
      if (WIDE_ID) begin : g_wide
         assign dest_in = load_dest;
      end else begin : g_narrow
         assign dest_in = {8'h00, load_dest[7:0]};
      end
   endgenerate

   assign done = tx_valid && tx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid   <= 1'b0;
         tx_dest_id <= '0;
         tx_info    <= '0;
         tx_prio    <= '0;
      end else if (!tx_valid && load) begin
         tx_valid   <= 1'b1;
         tx_dest_id <= dest_in;
         tx_info    <= load_info;
         tx_prio    <= load_prio;
      end else if (done) begin
         tx_valid   <= 1'b0;
      end
   end
endmodule

// File: rtl/dbell_regif.sv
module dbell_regif
   import dbell_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int RXQ_DEPTH = 16,
   parameter bit WIDE_ID   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rx_valid,
   input  logic [15:0]       rx_src_id,
   input  logic [15:0]       rx_info,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [1:0]        tx_prio,
   output logic [15:0]       tx_dest_id,
   output logic [15:0]       tx_info,
   output logic              irq
);
   localparam int LVL_W = $clog2(RXQ_DEPTH + 1);

   initial begin
      assert (ADDR_W >= 6) else $error("ADDR_W must cover offset 0x24");
      assert (RXQ_DEPTH >= 2 && RXQ_DEPTH <= 255) else $error("RXQ_DEPTH out of range");
   end

   logic [3:0]       word;
   logic             rd_pop, wr_prio, wr_txmsg, wr_en, wr_sts;
   dbell_msg_t       rx_in, q_head;
   logic [LVL_W-1:0] rx_level;
   logic             rx_acc, rx_drop, tx_done;
   logic [1:0]       prio_q;
   logic [EV_W-1:0]  irq_en_q, irq_sts_q, ev_set;
   logic [31:0]      rd_mux;
   logic             unused_bits;

   assign word     = reg_addr[5:2];
   assign rd_pop   = reg_rd && (word == W_RX_MSG);
   assign wr_prio  = reg_wr && (word == W_TX_PRIO);
   assign wr_txmsg = reg_wr && (word == W_TX_MSG);
   assign wr_en    = reg_wr && (word == W_IRQ_EN);
   assign wr_sts   = reg_wr && (word == W_IRQ_STS);
   assign unused_bits = ^{reg_addr[1:0], reg_addr[ADDR_W-1:6], reg_wdata[31:16]} | 1'b0;

   generate
      if (WIDE_ID) begin : g_rx_wide
         assign rx_in.src = rx_src_id;
      end else begin : g_rx_narrow
         assign rx_in.src = {8'h00, rx_src_id[7:0]};
      end
   endgenerate
   assign rx_in.info = rx_info;

   dbell_rxq #(.DEPTH(RXQ_DEPTH), .LVL_W(LVL_W)) u_rxq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (rx_valid),
      .push_msg (rx_in),
      .pop      (rd_pop),
      .head     (q_head),
      .level    (rx_level),
      .accepted (rx_acc),
      .dropped  (rx_drop)
   );

   dbell_txreq #(.WIDE_ID(WIDE_ID)) u_txreq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_txmsg),
      .load_dest  (reg_wdata[31:16]),
      .load_info  (reg_wdata[15:0]),
      .load_prio  (prio_q),
      .tx_ready   (tx_ready),
      .tx_valid   (tx_valid),
      .tx_dest_id (tx_dest_id),
      .tx_info    (tx_info),
      .tx_prio    (tx_prio),
      .done       (tx_done)
   );

   assign ev_set = {tx_done, rx_drop, rx_acc};
   assign irq    = |(irq_sts_q & irq_en_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q    <= '0;
         irq_en_q  <= '0;
         irq_sts_q <= '0;
      end else begin
         if (wr_prio) prio_q <= (reg_wdata[1:0] == 2'b11) ? 2'b10 : reg_wdata[1:0];
         if (wr_en)   irq_en_q <= reg_wdata[EV_W-1:0];
         irq_sts_q <= (irq_sts_q & ~(wr_sts ? reg_wdata[EV_W-1:0] : '0)) | ev_set;
      end
   end

   always_comb begin
      case (word)
         W_RX_MSG:  rd_mux = (rx_level == '0) ? '0 : {q_head.src, q_head.info};
         W_RX_LVL:  rd_mux = 32'(rx_level);
         W_TX_PRIO: rd_mux = 32'(prio_q);
         W_TX_MSG:  rd_mux = {tx_dest_id, tx_info};
         W_TX_STAT: rd_mux = 32'(tx_valid);
         W_IRQ_EN:  rd_mux = 32'(irq_en_q);
         W_IRQ_STS: rd_mux = 32'(irq_sts_q);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end
endmodule

// File: rtl/dbell_regif_chk.sv
module dbell_regif_chk #(
   parameter int ADDR_W    = 6,
   parameter int RXQ_DEPTH = 16,
   parameter int LVL_W     = 5,
   parameter bit WIDE_ID   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              rx_valid,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [1:0]        tx_prio,
   input logic [15:0]       tx_dest_id,
   input logic [15:0]       tx_info,
   input logic [LVL_W-1:0]  rx_level,
   input logic [2:0]        irq_sts
);
   logic [3:0] w;
   assign w = reg_addr[5:2];

   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= LVL_W'(RXQ_DEPTH));

   p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_level == LVL_W'(RXQ_DEPTH) && !(reg_rd && w == 4'd0))
      |=> (rx_level == LVL_W'(RXQ_DEPTH)) && irq_sts[1]);

   p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_wr && w == 4'd0 && rx_level == '0 && !rx_valid)
      |=> (reg_rdata == 32'd0) && (rx_level == '0));

   p_prio_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_prio != 2'b11);

   p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_dest_id)
                                  && $stable(tx_info) && $stable(tx_prio));

   p_drop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sts[1] && !(reg_wr && w == 4'd9 && reg_wdata[1])) |=> irq_sts[1]);

   generate
      if (!WIDE_ID) begin : g_narrow
         p_dest_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            tx_dest_id[15:8] == 8'h00);
         p_rx_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && w == 4'd0) |=> reg_rdata[31:24] == 8'h00);
      end
   endgenerate
endmodule

bind dbell_regif dbell_regif_chk #(
   .ADDR_W(ADDR_W), .RXQ_DEPTH(RXQ_DEPTH), .LVL_W(LVL_W), .WIDE_ID(WIDE_ID)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .rx_valid   (rx_valid),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_prio    (tx_prio),
   .tx_dest_id (tx_dest_id),
   .tx_info    (tx_info),
   .rx_level   (rx_level),
   .irq_sts    (irq_sts_q)
);

// File: tb/dbell_regif_bench.sv
module dbell_regif_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rdata_w, rdata_n;
   logic        rx_valid = 1'b0;
   logic [15:0] rx_src_id = '0, rx_info = '0;
   logic        tx_ready = 1'b0;
   logic        txv_w, txv_n, irq_w, irq_n;
   logic [1:0]  prio_w, prio_n;
   logic [15:0] dest_w, dest_n, info_w, info_n;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   dbell_regif #(.WIDE_ID(1'b1)) u_dbell_regif (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_w), .rx_valid(rx_valid),
      .rx_src_id(rx_src_id), .rx_info(rx_info), .tx_valid(txv_w), .tx_ready(tx_ready),
      .tx_prio(prio_w), .tx_dest_id(dest_w), .tx_info(info_w), .irq(irq_w));

   dbell_regif #(.WIDE_ID(1'b0)) u_dbell_regif_narrow (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .rx_valid(rx_valid),
      .rx_src_id(rx_src_id), .rx_info(rx_info), .tx_valid(txv_n), .tx_ready(tx_ready),
      .tx_prio(prio_n), .tx_dest_id(dest_n), .tx_info(info_n), .irq(irq_n));

   typedef struct packed {
      logic [5:0]  addr;
      logic [31:0] wdata;
      logic [31:0] exp;
   } vec_t;

   // write addr/wdata, read back, expect exp
   localparam vec_t [0:11] VECS = '{
      '{6'h08, 32'h0000_0001, 32'h0000_0001},   // R5
      '{6'h08, 32'h0000_0003, 32'h0000_0002},   // R5 coercion
      '{6'h08, 32'hFFFF_FFFF, 32'h0000_0002},   // R5 upper bits zero
      '{6'h08, 32'h0000_0000, 32'h0000_0000},   // R5
      '{6'h20, 32'hFFFF_FFFF, 32'h0000_0007},   // R7 enable width
      '{6'h20, 32'hFFFF_FFF8, 32'h0000_0000},   // R7
      '{6'h04, 32'h0000_0055, 32'h0000_0000},   // R9 level read-only
      '{6'h10, 32'h0000_0001, 32'h0000_0000},   // R9 tx status read-only
      '{6'h14, 32'hFFFF_FFFF, 32'h0000_0000},   // R9
      '{6'h18, 32'hFFFF_FFFF, 32'h0000_0000},   // R9
      '{6'h1C, 32'hFFFF_FFFF, 32'h0000_0000},   // R9
      '{6'h08, 32'h0000_0002, 32'h0000_0002}    // R5, leaves priority 2
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [5:0] a, output logic [31:0] dw, output logic [31:0] dn);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      dw = rdata_w; dn = rdata_n;
   endtask

   task automatic rx_push(input logic [15:0] s, input logic [15:0] i);
      @(negedge clk);
      rx_valid = 1'b1; rx_src_id = s; rx_info = i;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   function automatic logic [15:0] src_of(input int k);
      return 16'hA100 + 16'(k);
   endfunction
   function automatic logic [15:0] info_of(input int k);
      return 16'h5000 + 16'(k * 3);
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] dw, dn;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rdata", rdata_w, 32'h0);
      chk("R1 tx_valid", {31'b0, txv_w}, 32'h0);
      chk("R1 irq", {31'b0, irq_w}, 32'h0);
      reg_read(6'h04, dw, dn); chk("R1 level", dw, 32'h0);
      reg_read(6'h08, dw, dn); chk("R1 prio", dw, 32'h0);

      // table walk: R5 R7 R9
      for (int k = 0; k < 12; k++) begin
         reg_write(VECS[k].addr, VECS[k].wdata);
         reg_read(VECS[k].addr, dw, dn);
         chk($sformatf("R5/R7/R9 table %0d", k), dw, VECS[k].exp);
      end

      // R9 write to receive word with empty queue changes nothing
      reg_write(6'h00, 32'h1234_5678);
      reg_read(6'h04, dw, dn); chk("R9 rx word write", dw, 32'h0);

      // R6 transmit request
      reg_write(6'h0C, 32'hBEEF_C0DE);
      chk("R6 tx_valid", {31'b0, txv_w}, 32'h1);
      chk("R6 dest/info", {dest_w, info_w}, 32'hBEEF_C0DE);
      chk("R6 prio", {30'b0, prio_w}, 32'h2);
      chk("R8 narrow dest", {16'h0, dest_n}, 32'h0000_00EF);
      reg_read(6'h10, dw, dn); chk("R6 pending status", dw, 32'h1);
      reg_write(6'h0C, 32'h1111_2222);   // ignored while pending
      repeat (2) @(negedge clk);
      chk("R6 hold", {dest_w, info_w}, 32'hBEEF_C0DE);
      chk("R6 hold valid", {31'b0, txv_w}, 32'h1);
      reg_read(6'h0C, dw, dn); chk("R6 readback", dw, 32'hBEEF_C0DE);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      chk("R6 accepted", {31'b0, txv_w}, 32'h0);
      reg_read(6'h24, dw, dn); chk("R7 tx done bit", dw, 32'h4);
      reg_write(6'h24, 32'h7);
      reg_read(6'h24, dw, dn); chk("R7 w1c", dw, 32'h0);

      // R7 interrupt from message arrival
      rx_push(src_of(0), info_of(0));
      chk("R7 irq masked", {31'b0, irq_w}, 32'h0);
      reg_write(6'h20, 32'h1);
      chk("R7 irq enabled", {31'b0, irq_w}, 32'h1);
      reg_write(6'h24, 32'h2);            // clears other bit only
      chk("R7 irq other clear", {31'b0, irq_w}, 32'h1);
      reg_write(6'h24, 32'h1);
      chk("R7 irq cleared", {31'b0, irq_w}, 32'h0);

      // R3 fill to capacity then overflow
      for (int k = 1; k < 16; k++) rx_push(src_of(k), info_of(k));
      reg_read(6'h04, dw, dn); chk("R3 level full", dw, 32'd16);
      rx_push(16'hDEAD, 16'hDEAD);
      reg_read(6'h04, dw, dn); chk("R3 level after drop", dw, 32'd16);
      reg_read(6'h24, dw, dn); chk("R3 overflow bit", dw & 32'h2, 32'h2);

      // R2 ordered drain, R8 narrow upper byte
      for (int k = 0; k < 16; k++) begin
         reg_read(6'h00, dw, dn);
         chk($sformatf("R2 msg %0d", k), dw, {src_of(k), info_of(k)});
         chk($sformatf("R8 msg %0d", k), dn, {8'h00, src_of(k)[7:0], info_of(k)});
      end
      reg_read(6'h04, dw, dn); chk("R2 level drained", dw, 32'h0);

      // R4 empty read
      reg_read(6'h00, dw, dn); chk("R4 empty read", dw, 32'h0);
      reg_read(6'h04, dw, dn); chk("R4 level unchanged", dw, 32'h0);

      // R2 interleaved push/pop
      rx_push(16'h0102, 16'h0304);
      rx_push(16'h0506, 16'h0708);
      reg_read(6'h00, dw, dn); chk("R2 first", dw, 32'h0102_0304);
      reg_read(6'h04, dw, dn); chk("R2 level one", dw, 32'h1);
      reg_read(6'h00, dw, dn); chk("R2 second", dw, 32'h0506_0708);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule